// File: doc/BRIEF.md
# Synchronized DMA Request Router Channel

This block is one lane of a DMA request router. It chooses one request line out of a vector made of request-generator outputs and peripheral requests, using a programmable source number. The chosen line is passed to a single DMA channel request output. The DMA controller's acknowledge goes back only to the chosen source.

In unconditional mode the chosen request reaches the output as soon as it appears. In synchronized mode the request is held back until a chosen synchronization line shows the programmed edge. That edge opens a window. The window lets a programmed number of acknowledged requests through and then closes. A request counter reloads on each underrun. When enabled, each underrun also produces a one-cycle event pulse, which can drive the synchronization input of another channel.

Configuration comes in on plain input ports. The bench holds these ports steady whenever they matter.

Top module: `dma_req_router_ch`

## Requirements
- R1: A source number of 0 selects nothing. In that case `dma_req` stays low and no acknowledge output is driven, whatever the inputs are.
- R2: Source numbers 1 to N_GEN select `gen_req[id-1]`. Numbers N_GEN+1 to N_GEN+N_PERIPH select `periph_req[id-N_GEN-1]`. In unconditional mode (`cfg_sync_en`=0) the selected line appears on `dma_req` in the same cycle, with no register in the path.
- R3: `dma_ack` is returned in the same cycle to exactly the selected source's acknowledge bit, and to no other bit.
- R4: In synchronized mode a pending request is held off until an edge is seen on the selected synchronization line. The edge encoding in `cfg_sync_pol` is: 00 = never, 01 = rising, 10 = falling, 11 = either. The selected line passes through two flops before edge detection. As a result, `dma_req` rises after the third rising clock edge that follows the input change.
- R5: Once open, the window stays open for exactly `cfg_nbreq`+1 acknowledged requests. A request counts as acknowledged when `dma_ack` and `dma_req` are both high at a clock edge. The window closes at the edge of the last acknowledge and does not reopen until a new edge arrives.
- R6: With `cfg_evt_en`=1, `evt_out` is high for one cycle after each acknowledge that finds the counter at zero. The counter then reloads from `cfg_nbreq`. With `cfg_evt_en`=0, `evt_out` stays low.
- R7: In unconditional mode the counter still counts acknowledges. Events therefore appear after every `cfg_nbreq`+1 acknowledges, counted from reset.
- R8: A qualifying edge that arrives while the window is already open has no effect on the window. Instead it sets `sync_ovr`, which stays set until reset.
- R9: `cfg_sync_id` chooses which bit of `sync_in` is watched. Edges on the other bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset. Reset loads the counter from `cfg_nbreq`. |
| cfg_sel | input | SEL_W | Request source number |
| cfg_sync_en | input | 1 | 1 = synchronized mode |
| cfg_sync_id | input | SYNC_W | Synchronization line select |
| cfg_sync_pol | input | 2 | Edge select |
| cfg_nbreq | input | CNT_W | Requests per window, minus one |
| cfg_evt_en | input | 1 | Underrun event enable |
| gen_req | input | N_GEN | Request-generator request lines |
| periph_req | input | N_PERIPH | Peripheral request lines |
| sync_in | input | N_SYNC | Synchronization lines |
| dma_ack | input | 1 | Acknowledge from the DMA controller |
| gen_ack | output | N_GEN | Acknowledge to the request generators |
| periph_ack | output | N_PERIPH | Acknowledge to the peripherals |
| dma_req | output | 1 | Request to the DMA channel |
| evt_out | output | 1 | Underrun event pulse |
| sync_ovr | output | 1 | Sticky flag for an edge that arrived while the window was open |

## Verification
The bench builds the channel with N_GEN=2, N_PERIPH=3, N_SYNC=2 and CNT_W=3. This small configuration lets it try every source number, including the unused one, against every single active input and the acknowledge routing. It also covers all four edge encodings on both synchronization lines, and every window length from one to four requests. For each window length the event spacing is checked in both modes.

// File: rtl/dma_req_router_ch.sv
module dma_req_router_ch #(
  parameter int N_GEN    = 2,
  parameter int N_PERIPH = 3,
  parameter int N_SYNC   = 2,
  parameter int CNT_W    = 3,
  localparam int NSRC    = N_GEN + N_PERIPH + 1,
  localparam int SEL_W   = $clog2(NSRC),
  localparam int SYNC_W  = (N_SYNC > 1) ? $clog2(N_SYNC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic                cfg_sync_en,
  input  logic [SYNC_W-1:0]   cfg_sync_id,
  input  logic [1:0]          cfg_sync_pol,
  input  logic [CNT_W-1:0]    cfg_nbreq,
  input  logic                cfg_evt_en,
  input  logic [N_GEN-1:0]    gen_req,
  input  logic [N_PERIPH-1:0] periph_req,
  input  logic [N_SYNC-1:0]   sync_in,
  input  logic                dma_ack,
  output logic [N_GEN-1:0]    gen_ack,
  output logic [N_PERIPH-1:0] periph_ack,
  output logic                dma_req,
  output logic                evt_out,
  output logic                sync_ovr
);

  logic [NSRC-1:0]  src_vec, ack_vec;
  logic             sel_ok, sel_req, take;
  logic             sy1, sy2, sy3, sync_raw, sync_hit;
  logic             win_open;
  logic [CNT_W-1:0] cnt;

  assign sel_ok  = (cfg_sel != '0) && (32'(cfg_sel) < NSRC);
  assign src_vec = {periph_req, gen_req, 1'b0};
  assign sel_req = sel_ok && src_vec[cfg_sel];
  assign ack_vec = (dma_ack && sel_ok) ? (NSRC'(1) << cfg_sel) : '0;
  assign gen_ack    = ack_vec[N_GEN:1];
  assign periph_ack = ack_vec[NSRC-1:N_GEN+1];

  assign dma_req = sel_req && (!cfg_sync_en || win_open);
  assign take    = dma_req && dma_ack;

  assign sync_raw = (32'(cfg_sync_id) < N_SYNC) ? sync_in[cfg_sync_id] : 1'b0;
  assign sync_hit = (cfg_sync_pol[0] && sy2 && !sy3) ||
                    (cfg_sync_pol[1] && !sy2 && sy3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1      <= 1'b0;
      sy2      <= 1'b0;
      sy3      <= 1'b0;
      win_open <= 1'b0;
      cnt      <= cfg_nbreq;
      evt_out  <= 1'b0;
      sync_ovr <= 1'b0;
    end else begin
      sy1     <= sync_raw;
      sy2     <= sy1;
      sy3     <= sy2;
      evt_out <= take && (cnt == '0) && cfg_evt_en;
      if (take) begin
        if (cnt == '0) begin
          cnt <= cfg_nbreq;
          if (cfg_sync_en) win_open <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (cfg_sync_en && sync_hit) begin
        if (win_open) sync_ovr <= 1'b1;
        else begin
          win_open <= 1'b1;
          cnt      <= cfg_nbreq;
        end
      end
    end
  end

  a_r1_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == '0) |-> (!dma_req && gen_ack == '0 && periph_ack == '0));
  a_r3_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && dma_req) |-> ($countones({gen_ack, periph_ack}) == 1));
  a_r4_pol_never: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sync_en && cfg_sync_pol == 2'b00 && !win_open) |=> !win_open);
  a_r5_close_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sync_en && win_open && !take) |=> win_open);
  a_r6_evt_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    evt_out |-> $past(take && cfg_evt_en));
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ovr |=> sync_ovr);

endmodule

// File: tb/sim_dma_req_router_ch.sv
module sim_dma_req_router_ch;
  localparam int NG = 2, NP = 3, NS = 2, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic cfg_sync_en = 1'b0, cfg_evt_en = 1'b0;
  logic [0:0] cfg_sync_id = '0;
  logic [1:0] cfg_sync_pol = '0;
  logic [CW-1:0] cfg_nbreq = '0;
  logic [NG-1:0] gen_req = '0;
  logic [NP-1:0] periph_req = '0;
  logic [NS-1:0] sync_in = '0;
  logic dma_ack = 1'b0;
  logic [NG-1:0] gen_ack;
  logic [NP-1:0] periph_ack;
  logic dma_req, evt_out, sync_ovr;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dma_req_router_ch #(.N_GEN(NG), .N_PERIPH(NP), .N_SYNC(NS), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_sync_en(cfg_sync_en),
    .cfg_sync_id(cfg_sync_id), .cfg_sync_pol(cfg_sync_pol), .cfg_nbreq(cfg_nbreq),
    .cfg_evt_en(cfg_evt_en), .gen_req(gen_req), .periph_req(periph_req),
    .sync_in(sync_in), .dma_ack(dma_ack), .gen_ack(gen_ack), .periph_ack(periph_ack),
    .dma_req(dma_req), .evt_out(evt_out), .sync_ovr(sync_ovr));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic ack_pulse();
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(!dma_req && !evt_out && !sync_ovr, "reset R1", int'({dma_req, evt_out, sync_ovr}), 0);

    // R1 R2 R3: every source number against every single active line
    for (int s = 0; s < 6; s++) begin
      for (int j = 0; j < NG + NP; j++) begin
        logic [4:0] v;
        logic [4:0] ea;
        v = 5'(1) << j;
        @(negedge clk);
        cfg_sel = 3'(s);
        {periph_req, gen_req} = v;
        #1;
        chk(dma_req == (s != 0 && s - 1 == j), (s == 0) ? "R1 sel0" : "R2 map",
            int'(dma_req), int'(s != 0 && s - 1 == j));
        dma_ack = 1'b1;
        #1;
        ea = (s == 0) ? 5'd0 : 5'(1) << (s - 1);
        chk({periph_ack, gen_ack} == ea, "R3 ack route", int'({periph_ack, gen_ack}), int'(ea));
        dma_ack = 1'b0;
        #1;
        chk({periph_ack, gen_ack} == 5'd0, "R3 ack drop", int'({periph_ack, gen_ack}), 0);
      end
    end
    {periph_req, gen_req} = '0;

    // R6 R7: unconditional mode event spacing
    for (int k = 0; k < 4; k++) begin
      for (int en = 0; en < 2; en++) begin
        int nevt;
        cfg_sync_en = 1'b0; cfg_sel = 3'd4; cfg_nbreq = 3'(k); cfg_evt_en = en[0];
        periph_req = 3'b010;
        do_reset();
        nevt = 0;
        for (int a = 0; a < 8; a++) begin
          bit exp;
          ack_pulse();
          exp = (en == 1) && ((a + 1) % (k + 1) == 0);
          chk(evt_out == exp, (en == 1) ? "R7 evt spacing" : "R6 evt disabled", int'(evt_out), int'(exp));
          if (evt_out) nevt++;
          @(negedge clk);
          chk(!evt_out, "R6 one cycle", int'(evt_out), 0);
        end
        chk(nevt == ((en == 1) ? 8 / (k + 1) : 0), "R7 evt count", nevt, (en == 1) ? 8 / (k + 1) : 0);
      end
    end

    // R4 R9: every edge encoding on both lines
    for (int id = 0; id < 2; id++) begin
      for (int p = 0; p < 4; p++) begin
        cfg_sync_en = 1'b1; cfg_sync_id = 1'(id); cfg_sync_pol = 2'(p);
        cfg_nbreq = 3'd3; cfg_sel = 3'd1; gen_req = 2'b01; periph_req = '0;
        sync_in = '0;
        do_reset();
        cyc(2);
        chk(!dma_req, "R4 held", int'(dma_req), 0);
        sync_in[1 - id] = 1'b1; cyc(5); sync_in[1 - id] = 1'b0; cyc(5);
        chk(!dma_req, "R9 other line", int'(dma_req), 0);
        // rising edge on selected line
        sync_in[id] = 1'b1;
        cyc(2);
        chk(!dma_req, "R4 latency rise", int'(dma_req), 0);
        @(negedge clk);
        chk(dma_req == p[0], "R4 rise", int'(dma_req), p[0]);
        if (!dma_req) begin
          cyc(2);
          sync_in[id] = 1'b0;
          cyc(2);
          chk(!dma_req, "R4 latency fall", int'(dma_req), 0);
          @(negedge clk);
          chk(dma_req == p[1], "R4 fall", int'(dma_req), p[1]);
        end
        sync_in = '0;
      end
    end

    // R5 R6: window length sweep
    for (int k = 0; k < 4; k++) begin
      cfg_sync_en = 1'b1; cfg_sync_id = 1'b0; cfg_sync_pol = 2'b01;
      cfg_nbreq = 3'(k); cfg_evt_en = 1'b1; cfg_sel = 3'd5; periph_req = 3'b100; gen_req = '0;
      sync_in = '0;
      do_reset();
      sync_in[0] = 1'b1; cyc(3);
      for (int a = 0; a <= k; a++) begin
        chk(dma_req, "R5 open", int'(dma_req), 1);
        ack_pulse();
        chk(evt_out == (a == k), "R6 evt at close", int'(evt_out), int'(a == k));
      end
      chk(!dma_req, "R5 closed", int'(dma_req), 0);
      cyc(6);
      chk(!dma_req, "R5 stays closed", int'(dma_req), 0);
      sync_in[0] = 1'b0; cyc(4);
      sync_in[0] = 1'b1; cyc(3);
      chk(dma_req, "R5 reopen", int'(dma_req), 1);
      sync_in = '0;
    end

    // R8: edge while open
    cfg_nbreq = 3'd2; cfg_sync_pol = 2'b11;
    do_reset();
    sync_in[0] = 1'b1; cyc(3);
    chk(dma_req && !sync_ovr, "R8 before", int'(sync_ovr), 0);
    ack_pulse();
    sync_in[0] = 1'b0; cyc(4);
    chk(sync_ovr, "R8 flag", int'(sync_ovr), 1);
    ack_pulse();
    chk(dma_req, "R8 window unchanged", int'(dma_req), 1);
    ack_pulse();
    chk(!dma_req, "R8 closes on count", int'(dma_req), 0);
    cyc(3);
    chk(sync_ovr, "R8 sticky", int'(sync_ovr), 1);
    do_reset();
    @(negedge clk);
    chk(!sync_ovr, "R8 reset clears", int'(sync_ovr), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule